// File: doc/BRIEF.md
# Reset configuration word loader

After reset, this sequencer reads the boot-time configuration bytes from a byte-wide memory behind the boot chip select. It builds one 32-bit word for the master device from four bytes placed eight addresses apart. It then reads seven more words of the same shape for slave devices. The slave words are read every time, whether or not any slave is fitted.

When the last byte is in, two bits of the master word pick the boot memory region base and the first instruction fetch address. The block then raises a done flag that stays high until the next reset. Nothing that fetches code should start before that flag is high. Bus timing, the external bus controller and the processor core are outside the block.

The block has two states. In `ST_READ` it issues read requests. On the acknowledge that completes the eighth word it moves to `ST_DONE`, and it stays there until reset.

Top module: `rcw_loader`

## Requirements
- R1: A synchronous active-high reset puts the block in `ST_READ`. It clears the master word, the slave word, the slave index and the valid pulse, sets the read address to 0x00 and drops the done flag. The request is high while in `ST_READ`, so a new sequence starts on the first cycle after reset is released.
- R2: The master word is built from the bytes at 0x00, 0x08, 0x10 and 0x18. The byte at 0x00 lands in bits 31:24, the byte at 0x08 in bits 23:16, the byte at 0x10 in bits 15:8 and the byte at 0x18 in bits 7:0.
- R3: While the request is high and no acknowledge arrives, the address holds. On an acknowledge the byte is captured and the address steps by 8 on the next cycle.
- R4: After the master word, reading continues from 0x20 through 0xF8, 28 bytes in all, so seven slave words are always read. Each slave word uses the same lane order as R2.
- R5: As each slave word completes, the slave valid output pulses high for exactly one cycle. On that cycle the slave word and an index from 0 to 6, in read order, are presented. The index is 0 for the word at 0x20 to 0x38.
- R6: The transition `ST_READ` to `ST_DONE` happens on the 32nd acknowledge. The done flag then rises together with the last slave pulse and stays high until reset, and the request stays low while done is high.
- R7: If master word bit 20 (boot-memory-select) is 0, the boot base is 0xFE00_0000. If it is 1, the boot base is 0x0000_0000.
- R8: If master word bit 19 (vector-prefix) is 0, the fetch start address is 0xFFF0_0100. If it is 1, the fetch start address is 0x0000_0100.
- R9: A reset in the middle of a sequence abandons it. The address returns to 0x00, the words are cleared and done stays low, and a full new sequence follows once reset is released.
- R10: Acknowledges that arrive while done is high have no effect. The master word, the slave outputs and the done flag keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | output | 1 | Read request to the boot memory |
| rd_addr | output | 8 | Byte address of the current read |
| rd_ack | input | 1 | Read acknowledge; data is valid on this cycle |
| rd_data | input | 8 | Byte returned by the boot memory |
| master_word | output | 32 | Assembled master configuration word |
| slave_vld | output | 1 | One-cycle pulse as a slave word completes |
| slave_idx | output | 3 | Slave number 0 to 6 for the current pulse |
| slave_word | output | 32 | Assembled slave configuration word |
| boot_base | output | 32 | Base of the boot memory region |
| fetch_addr | output | 32 | First instruction fetch address |
| cfg_done | output | 1 | Sequence finished; code fetch may begin |

## Verification
Every captured byte shows at the ports one cycle after the clock edge that sampled its acknowledge. On that cycle the address has stepped, and the master word or the slave pulse has updated if the byte closed a word. `cfg_done` rises on the same cycle as the seventh slave pulse. The boot base and fetch address follow the master word with no extra delay. The bench drives acknowledges on falling edges and keeps a reference model that advances on each rising edge. All outputs are compared at the next falling edge, so each result is checked in the one cycle it is due. Acknowledge gaps of zero to two cycles, a reset in the middle of a sequence, and acknowledges sent after done cover the hold, restart and ignore cases.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;

    typedef enum logic [0:0] {
        ST_READ = 1'b0,
        ST_DONE = 1'b1
    } rcw_state_e;
endpackage

// File: rtl/rcw_seq_fsm.sv
module rcw_seq_fsm
    import rcw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STRIDE = 8,
    parameter int SLAVES = 7,
    localparam int BCNT_W = $clog2(WORD_BYTES),
    localparam int WIDX_W = $clog2(SLAVES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              take,
    output logic              byte_last,
    output logic [WIDX_W-1:0] word_idx,
    output logic              seq_done
);
    rcw_state_e        state, state_nxt;
    logic [BCNT_W-1:0] byte_cnt;
    logic              word_last;

    assign byte_last = (byte_cnt == BCNT_W'(WORD_BYTES - 1));
    assign word_last = (word_idx == WIDX_W'(SLAVES));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_READ;
        else     state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_READ: if (rd_ack && byte_last && word_last) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_DONE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req   = 1'b0;
        seq_done = 1'b0;
        unique case (state)
            ST_READ: rd_req   = 1'b1;
            ST_DONE: seq_done = 1'b1;
        endcase
    end

    assign take = rd_req && rd_ack;

    // address and position counters
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr  <= '0;
            byte_cnt <= '0;
            word_idx <= '0;
        end else if (take) begin
            rd_addr  <= rd_addr + ADDR_W'(STRIDE);
            byte_cnt <= byte_cnt + 1'b1;
            if (byte_last) word_idx <= word_idx + 1'b1;
        end
    end
endmodule

// File: rtl/rcw_word_asm.sv
module rcw_word_asm
    import rcw_pkg::*;
#(
    parameter int SLAVES = 7,
    localparam int WIDX_W = $clog2(SLAVES + 1),
    localparam int IDX_W  = $clog2(SLAVES),
    localparam int SH_W   = WORD_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              byte_last,
    input  logic [WIDX_W-1:0] word_idx,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [WORD_W-1:0] master_word,
    output logic [WORD_W-1:0] slave_word,
    output logic              slave_vld,
    output logic [IDX_W-1:0]  slave_idx
);
    logic [SH_W-1:0]   shreg;
    logic [WORD_W-1:0] full;

    // earliest byte ends up in the top lane
    assign full = {shreg, rd_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg       <= '0;
            master_word <= '0;
            slave_word  <= '0;
            slave_vld   <= 1'b0;
            slave_idx   <= '0;
        end else begin
            slave_vld <= 1'b0;
            if (take) begin
                shreg <= full[SH_W-1:0];
                if (byte_last) begin
                    if (word_idx == '0) begin
                        master_word <= full;
                    end else begin
                        slave_word <= full;
                        slave_vld  <= 1'b1;
                        slave_idx  <= IDX_W'(word_idx - 1'b1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rcw_boot_map.sv
module rcw_boot_map
    import rcw_pkg::*;
#(
    parameter int              BMS_BIT   = 20,
    parameter int              VPF_BIT   = 19,
    parameter logic [WORD_W-1:0] BASE_HI = 32'hFE00_0000,
    parameter logic [WORD_W-1:0] VEC_HI  = 32'hFFF0_0000,
    parameter logic [WORD_W-1:0] VEC_OFF = 32'h0000_0100
) (
    input  logic [WORD_W-1:0] master_word,
    output logic [WORD_W-1:0] boot_base,
    output logic [WORD_W-1:0] fetch_addr
);
    always_comb begin
        boot_base  = master_word[BMS_BIT] ? '0 : BASE_HI;
        fetch_addr = (master_word[VPF_BIT] ? '0 : VEC_HI) | VEC_OFF;
    end
endmodule

// File: rtl/rcw_loader.sv
module rcw_loader
    import rcw_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int STRIDE  = 8,
    parameter int SLAVES  = 7,
    parameter int BMS_BIT = 20,
    parameter int VPF_BIT = 19
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic [31:0]       master_word,
    output logic              slave_vld,
    output logic [2:0]        slave_idx,
    output logic [31:0]       slave_word,
    output logic [31:0]       boot_base,
    output logic [31:0]       fetch_addr,
    output logic              cfg_done
);
    localparam int WIDX_W = $clog2(SLAVES + 1);

    logic              take, byte_last;
    logic [WIDX_W-1:0] word_idx;

    rcw_seq_fsm #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .SLAVES(SLAVES)) u_fsm (
        .clk(clk), .rst(rst), .rd_ack(rd_ack),
        .rd_req(rd_req), .rd_addr(rd_addr), .take(take),
        .byte_last(byte_last), .word_idx(word_idx), .seq_done(cfg_done)
    );

    rcw_word_asm #(.SLAVES(SLAVES)) u_asm (
        .clk(clk), .rst(rst), .take(take), .byte_last(byte_last),
        .word_idx(word_idx), .rd_data(rd_data),
        .master_word(master_word), .slave_word(slave_word),
        .slave_vld(slave_vld), .slave_idx(slave_idx)
    );

    rcw_boot_map #(.BMS_BIT(BMS_BIT), .VPF_BIT(VPF_BIT)) u_map (
        .master_word(master_word), .boot_base(boot_base), .fetch_addr(fetch_addr)
    );
endmodule

// File: rtl/rcw_loader_chk.sv
module rcw_loader_chk #(
    parameter int ADDR_W  = 8,
    parameter int STRIDE  = 8,
    parameter int SLAVES  = 7,
    parameter int BMS_BIT = 20,
    parameter int VPF_BIT = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic [31:0]       master_word,
    input logic              slave_vld,
    input logic [2:0]        slave_idx,
    input logic [31:0]       slave_word,
    input logic [31:0]       boot_base,
    input logic [31:0]       fetch_addr,
    input logic              cfg_done
);
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack |=> $stable(rd_addr));
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_ack |=> rd_addr == ADDR_W'($past(rd_addr) + ADDR_W'(STRIDE)));
    a_r5_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        slave_vld |=> !slave_vld);
    a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
        slave_vld |-> slave_idx < 3'(SLAVES));
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);
    a_r6_no_req_done: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> !rd_req);
    a_r7_base_sel: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> boot_base == (master_word[BMS_BIT] ? 32'h0 : 32'hFE00_0000));
    a_r8_fetch_sel: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> fetch_addr == (master_word[VPF_BIT] ? 32'h100 : 32'hFFF0_0100));
    a_r10_ignore_ack: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> $stable(master_word) && $stable(slave_word) && !slave_vld);
endmodule

bind rcw_loader rcw_loader_chk #(
    .ADDR_W(ADDR_W), .STRIDE(STRIDE), .SLAVES(SLAVES),
    .BMS_BIT(BMS_BIT), .VPF_BIT(VPF_BIT)
) u_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .master_word(master_word), .slave_vld(slave_vld), .slave_idx(slave_idx),
    .slave_word(slave_word), .boot_base(boot_base), .fetch_addr(fetch_addr),
    .cfg_done(cfg_done)
);

// File: tb/sim_rcw_loader.sv
`timescale 1ns/1ps
module sim_rcw_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req, rd_ack = 1'b0;
    logic [7:0]  rd_addr, rd_data = 8'h00;
    logic [31:0] master_word, slave_word, boot_base, fetch_addr;
    logic        slave_vld, cfg_done;
    logic [2:0]  slave_idx;

    always #2 clk = ~clk;

    rcw_loader u0 (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .master_word(master_word),
        .slave_vld(slave_vld), .slave_idx(slave_idx), .slave_word(slave_word),
        .boot_base(boot_base), .fetch_addr(fetch_addr), .cfg_done(cfg_done)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int pat = 0;
    bit bms_sel = 0, vpf_sel = 0, drive_en = 0, poke_en = 0, armed = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [7:0] a);
        if (a == 8'h08) return {3'b000, bms_sel, vpf_sel, 3'(pat)};
        return a ^ (8'(pat) * 8'h35) ^ 8'h5A;
    endfunction

    // reference model: integers counting accepted bytes
    int          m_cnt;
    bit          m_done, m_vld;
    logic [31:0] m_tmp, m_master, m_slave;
    int          m_idx;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_done = 0; m_vld = 0; m_tmp = 0;
            m_master = 0; m_slave = 0; m_idx = 0; armed = 1;
        end else begin
            m_vld = 0;
            if (!m_done && rd_ack) begin
                m_tmp[(3 - m_cnt % 4) * 8 +: 8] = rd_data;
                if (m_cnt % 4 == 3) begin
                    if (m_cnt / 4 == 0) m_master = m_tmp;
                    else begin m_slave = m_tmp; m_vld = 1; m_idx = m_cnt / 4 - 1; end
                end
                m_cnt++;
                if (m_cnt == 32) m_done = 1;
            end
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        if (armed) begin
            chk(rd_req == !m_done, "R6 req", 32'(rd_req), 32'(!m_done));
            if (!m_done) chk(rd_addr == 8'(m_cnt * 8), "R3 addr", 32'(rd_addr), 32'(m_cnt * 8));
            chk(master_word == m_master, "R2 master", master_word, m_master);
            chk(slave_vld == m_vld, "R5 vld", 32'(slave_vld), 32'(m_vld));
            if (m_vld) chk(slave_idx == 3'(m_idx), "R5 idx", 32'(slave_idx), 32'(m_idx));
            chk(slave_word == m_slave, "R4 slave", slave_word, m_slave);
            chk(cfg_done == m_done, "R6 done", 32'(cfg_done), 32'(m_done));
            chk(boot_base == (m_master[20] ? 32'h0 : 32'hFE00_0000), "R7 base",
                boot_base, m_master[20] ? 32'h0 : 32'hFE00_0000);
            chk(fetch_addr == (m_master[19] ? 32'h100 : 32'hFFF0_0100), "R8 fetch",
                fetch_addr, m_master[19] ? 32'h100 : 32'hFFF0_0100);
        end
    end

    // memory responder with variable gaps
    int wait_ctr = 0;
    always @(negedge clk) begin
        if (rst || !drive_en) begin
            rd_ack = 0; wait_ctr = 0;
        end else if (cfg_done) begin
            rd_ack = poke_en; rd_data = 8'hEE;
        end else if (rd_req) begin
            if (wait_ctr == 0) begin
                rd_ack = 1; rd_data = mem_byte(rd_addr);
                wait_ctr = (int'(rd_addr[5:3]) + pat) % 3;
            end else begin
                rd_ack = 0; wait_ctr--;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk(0, "R6 watchdog", 32'(cyc), 32'd20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_full(input int p, input bit b, input bit v);
        logic [31:0] exp_m;
        pat = p; bms_sel = b; vpf_sel = v;
        @(negedge clk); rst = 1; drive_en = 0;
        repeat (2) @(negedge clk);
        rst = 0; drive_en = 1;
        wait (cfg_done);
        @(negedge clk);
        exp_m = {mem_byte(8'h00), mem_byte(8'h08), mem_byte(8'h10), mem_byte(8'h18)};
        chk(master_word == exp_m, "R2 lanes", master_word, exp_m);
        chk(boot_base == (b ? 32'h0 : 32'hFE00_0000), "R7 sel", boot_base, b ? 32'h0 : 32'hFE00_0000);
        chk(fetch_addr == (v ? 32'h100 : 32'hFFF0_0100), "R8 sel", fetch_addr, v ? 32'h100 : 32'hFFF0_0100);
        poke_en = 1;
        repeat (3) @(negedge clk);
        poke_en = 0;
        chk(master_word == exp_m && cfg_done && !slave_vld, "R10 ignore", master_word, exp_m);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        chk(rd_req && rd_addr == 8'h00 && !cfg_done && master_word == 0 && !slave_vld,
            "R1 reset", {master_word[23:0], rd_addr}, 32'h0);
        run_full(0, 0, 0);
        run_full(1, 1, 1);
        run_full(2, 1, 0);
        // R9: abort mid-sequence
        pat = 3; bms_sel = 0; vpf_sel = 1;
        @(negedge clk); rst = 1; drive_en = 0;
        repeat (2) @(negedge clk);
        rst = 0; drive_en = 1;
        wait (m_cnt >= 10);
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        chk(rd_addr == 8'h00 && master_word == 0 && slave_word == 0 && !cfg_done,
            "R9 restart", {master_word[23:0], rd_addr}, 32'h0);
        run_full(3, 0, 1);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule